// File: doc/BRIEF.md
# Key-Guarded Two-Stage Watchdog Timer

This block is a watchdog timer. Software reaches it through a 64-byte register window. Writes arrive on a simple single-cycle write port, and reads come back one clock after the address is presented. Once the counter is enabled, it runs down a first preload value and then a second one. When the second stage reaches zero, the block sets a sticky timeout flag. If the reset action is enabled, it also raises a one-cycle reset-request pulse, which tells the system to restart. Software keeps the system alive by issuing a reload strobe before that happens.

Some registers are protected: the two preload values and the reload/flag register. A write to one of them lands only if a two-byte key was written to the key register just before it. A lock bit freezes the configuration, the preloads and the lock/enable register until the next reset. Two resets exist. The power-on reset clears everything. The system reset, which is the one the watchdog itself requests, clears everything except the timeout flag, so software can see after the restart that the watchdog fired.

Top module: `keyed_watchdog`

## Requirements
- R1: After power-on reset, every readable register, the down counter and the outputs `rst_req`, `rst_cold` and `tmo_out` are 0.
- R2: Protected registers are the preload values at 0x00 and 0x04 and the reload register at 0x0D. A write to one of them takes effect only when the two previous writes were 0x80 and then 0x86 to the key register 0x0C. Without that key, the write is discarded.
- R3: If a write that is not 0x86 to 0x0C follows the 0x80 (another key byte or a write to any other offset), the key sequence is abandoned. The next protected write is then discarded.
- R4: One key sequence admits exactly one write. Any write made after the key closes the window, so a second protected write is discarded.
- R5: When enabled, the counter loads preload 1 (value N). After N+1 ticks it switches to preload 2 (value M). After M+1 further ticks it expires. At expiry `rst_req` is high for exactly one cycle, and only if configuration bit 4 (reset action enable) is 1.
- R6: Configuration register 0x10 bit 2 selects the tick rate: 0 gives one tick every DIV_FAST clocks, 1 gives one tick every DIV_SLOW clocks. The register reads back its bits 2..5.
- R7: Writing 1 to bit 0 of 0x0D after the key restarts stage 1 from preload 1 and clears the prescaler. Offset 0x14 reads the live count, and writes to 0x14 are ignored.
- R8: Bit 1 of 0x0D is a flag that is set at every expiry, whether or not the reset action is enabled. Writing 1 to it after the key clears it. `tmo_out` follows the flag ANDed with configuration bit 5, one cycle later.
- R9: Lock register 0x18 holds bit 0 (lock), bit 1 (enable) and bit 2 (halt mode). Once the lock bit is 1, writes to 0x00, 0x04, 0x10 and 0x18 are ignored until a reset. Reload strobes are still accepted.
- R10: Writing 0 to bit 1 of 0x18 while unlocked stops the counter and holds its value. A 0-to-1 change of that bit reloads stage 1.
- R11: At expiry with halt mode 1, the counter stops at 0 and requests no further reset until a reload. With halt mode 0, it restarts stage 1 from preload 1.
- R12: `sys_rst` clears every register and output except the timeout flag. Only `por` clears the flag.
- R13: `rst_cold` takes the value of configuration bit 3 at each reset-request pulse and holds it until the next pulse or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high, clears everything |
| sys_rst | input | 1 | System reset, synchronous, active high, keeps the timeout flag |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 6 | Byte offset of the write |
| wr_data | input | 32 | Write data (byte registers use bits 7..0) |
| rd_addr | input | 6 | Byte offset to read |
| rd_data | output | 32 | Registered read data, valid one cycle after `rd_addr` |
| rst_req | output | 1 | One-cycle reset request at second-stage expiry |
| rst_cold | output | 1 | Reset type selected when the last request was raised |
| tmo_out | output | 1 | Timeout flag gated by the output enable |

## Verification
The hardest states to reach from the ports are the exact expiry cycle and what follows it: the one-cycle pulse, the restart or halt, and the flag surviving a system reset. These states only arise after two full countdowns. The bench therefore loads small preloads and shrinks both prescaler divisors. It then counts clock edges from the enabling write to the pulse, which exposes any off-by-one in either stage or in the prescaler. A locked configuration that is still reloadable is reached by enabling through the same write that sets the lock, and then attempting every blocked write.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  typedef enum logic [1:0] {KEY_IDLE, KEY_HALF, KEY_OPEN} key_state_e;

  localparam logic [5:0] OFS_PRE1 = 6'h00;
  localparam logic [5:0] OFS_PRE2 = 6'h04;
  localparam logic [5:0] OFS_KEY  = 6'h0C;
  localparam logic [5:0] OFS_RLD  = 6'h0D;
  localparam logic [5:0] OFS_CFG  = 6'h10;
  localparam logic [5:0] OFS_CNT  = 6'h14;
  localparam logic [5:0] OFS_LCK  = 6'h18;

  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;

  // bit positions software decodes
  localparam int RLD_STROBE = 0;
  localparam int RLD_FLAG   = 1;
  localparam int CFG_SLOW   = 2;
  localparam int CFG_COLD   = 3;
  localparam int CFG_RSTEN  = 4;
  localparam int CFG_OUTEN  = 5;
  localparam int LCK_LOCK   = 0;
  localparam int LCK_EN     = 1;
  localparam int LCK_HALT   = 2;
endpackage

// File: rtl/kwd_unlock.sv
module kwd_unlock
  import kwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [5:0] wr_addr,
  input  logic [7:0] wr_byte,
  output logic       key_open
);
  key_state_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= KEY_IDLE;
    end else if (wr_en) begin
      if (wr_addr == OFS_KEY) begin
        if (wr_byte == KEY_FIRST)
          st_q <= KEY_HALF;
        else if (st_q == KEY_HALF && wr_byte == KEY_SECOND)
          st_q <= KEY_OPEN;
        else
          st_q <= KEY_IDLE;
      end else begin
        st_q <= KEY_IDLE;
      end
    end
  end

  assign key_open = (st_q == KEY_OPEN);
endmodule

// File: rtl/kwd_prescale.sv
module kwd_prescale #(
  parameter int DIV_FAST = 32,
  parameter int DIV_SLOW = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  input  logic slow,
  output logic tick
);
  localparam int PW = $clog2(DIV_SLOW + 1);
  localparam logic [PW-1:0] LIM_FAST = PW'(DIV_FAST - 1);
  localparam logic [PW-1:0] LIM_SLOW = PW'(DIV_SLOW - 1);

  logic [PW-1:0] div_q;
  logic [PW-1:0] limit;

  assign limit = slow ? LIM_SLOW : LIM_FAST;
  assign tick  = run && (div_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || clear)
      div_q <= '0;
    else if (run)
      div_q <= tick ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             tick,
  input  logic             halt_mode,
  input  logic [CNT_W-1:0] pre1,
  input  logic [CNT_W-1:0] pre2,
  output logic [CNT_W-1:0] count,
  output logic             halted,
  output logic             fire
);
  logic second_q;

  assign fire = tick && second_q && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      second_q <= 1'b0;
      halted   <= 1'b0;
    end else if (load) begin
      count    <= pre1;
      second_q <= 1'b0;
      halted   <= 1'b0;
    end else if (tick) begin
      if (count != '0) begin
        count <= count - 1'b1;
      end else if (!second_q) begin
        count    <= pre2;
        second_q <= 1'b1;
      end else if (halt_mode) begin
        halted <= 1'b1;
      end else begin
        count    <= pre1;
        second_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int DIV_FAST = 32,
  parameter int DIV_SLOW = 32768
) (
  input  logic        clk,
  input  logic        por,
  input  logic        sys_rst,
  input  logic        wr_en,
  input  logic [5:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [5:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        rst_req,
  output logic        rst_cold,
  output logic        tmo_out
);
  logic any_rst;
  assign any_rst = por || sys_rst;

  logic             key_open;
  logic [CNT_W-1:0] pre1_q, pre2_q, count;
  logic             cfg_slow, cfg_cold, cfg_rsten, cfg_outen;
  logic             lock_q, en_q, halt_q;
  logic             flag_q;
  logic             halted, fire, tick;

  kwd_unlock u_key (
    .clk(clk), .rst(any_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_byte(wr_data[7:0]), .key_open(key_open)
  );

  // write decode
  logic w_pre1, w_pre2, w_rld, w_cfg, w_lck, strobe, flag_clr, en_rise, load;
  assign w_pre1   = wr_en && wr_addr == OFS_PRE1 && key_open && !lock_q;
  assign w_pre2   = wr_en && wr_addr == OFS_PRE2 && key_open && !lock_q;
  assign w_rld    = wr_en && wr_addr == OFS_RLD  && key_open;
  assign w_cfg    = wr_en && wr_addr == OFS_CFG  && !lock_q;
  assign w_lck    = wr_en && wr_addr == OFS_LCK  && !lock_q;
  assign strobe   = w_rld && wr_data[RLD_STROBE];
  assign flag_clr = w_rld && wr_data[RLD_FLAG];
  assign en_rise  = w_lck && wr_data[LCK_EN] && !en_q;
  assign load     = strobe || en_rise;

  always_ff @(posedge clk) begin
    if (any_rst) begin
      pre1_q    <= '0;
      pre2_q    <= '0;
      cfg_slow  <= 1'b0;
      cfg_cold  <= 1'b0;
      cfg_rsten <= 1'b0;
      cfg_outen <= 1'b0;
      lock_q    <= 1'b0;
      en_q      <= 1'b0;
      halt_q    <= 1'b0;
    end else begin
      if (w_pre1) pre1_q <= wr_data[CNT_W-1:0];
      if (w_pre2) pre2_q <= wr_data[CNT_W-1:0];
      if (w_cfg) begin
        cfg_slow  <= wr_data[CFG_SLOW];
        cfg_cold  <= wr_data[CFG_COLD];
        cfg_rsten <= wr_data[CFG_RSTEN];
        cfg_outen <= wr_data[CFG_OUTEN];
      end
      if (w_lck) begin
        lock_q <= wr_data[LCK_LOCK];
        en_q   <= wr_data[LCK_EN];
        halt_q <= wr_data[LCK_HALT];
      end
    end
  end

  kwd_prescale #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_pre (
    .clk(clk), .rst(any_rst), .run(en_q && !halted), .clear(load),
    .slow(cfg_slow), .tick(tick)
  );

  kwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(any_rst), .load(load), .tick(tick), .halt_mode(halt_q),
    .pre1(pre1_q), .pre2(pre2_q), .count(count), .halted(halted), .fire(fire)
  );

  // sticky flag: only power-on reset clears it
  always_ff @(posedge clk) begin
    if (por)
      flag_q <= 1'b0;
    else if (fire)
      flag_q <= 1'b1;
    else if (flag_clr)
      flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (any_rst) begin
      rst_req  <= 1'b0;
      rst_cold <= 1'b0;
      tmo_out  <= 1'b0;
    end else begin
      rst_req <= fire && cfg_rsten;
      if (fire && cfg_rsten) rst_cold <= cfg_cold;
      tmo_out <= flag_q && cfg_outen;
    end
  end

  always_ff @(posedge clk) begin
    if (any_rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        OFS_PRE1: rd_data <= 32'(pre1_q);
        OFS_PRE2: rd_data <= 32'(pre2_q);
        OFS_RLD:  rd_data <= {30'b0, flag_q, 1'b0};
        OFS_CFG:  rd_data <= {26'b0, cfg_outen, cfg_rsten, cfg_cold, cfg_slow, 2'b0};
        OFS_CNT:  rd_data <= 32'(count);
        OFS_LCK:  rd_data <= {29'b0, halt_q, en_q, lock_q};
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             por,
  input logic             sys_rst,
  input logic             wr_en,
  input logic [5:0]       wr_addr,
  input logic             key_open,
  input logic [CNT_W-1:0] pre1_q,
  input logic             cfg_rsten,
  input logic             lock_q,
  input logic             flag_q,
  input logic             rst_req
);
  // R5
  pulse_len_chk: assert property (@(posedge clk) disable iff (por || sys_rst)
    rst_req |=> !rst_req);

  // R8
  req_sets_flag_chk: assert property (@(posedge clk) disable iff (por || sys_rst)
    rst_req |-> flag_q);

  // R2
  key_gate_chk: assert property (@(posedge clk) disable iff (por || sys_rst)
    !$stable(pre1_q) |-> $past(key_open && wr_en));

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (por || sys_rst)
    lock_q |=> (lock_q && $stable(pre1_q) && $stable(cfg_rsten)));

  // R12
  flag_clear_chk: assert property (@(posedge clk) disable iff (por)
    $fell(flag_q) |-> $past(key_open && wr_en && wr_addr == 6'h0D));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .por(por), .sys_rst(sys_rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .key_open(key_open), .pre1_q(pre1_q), .cfg_rsten(cfg_rsten),
  .lock_q(lock_q), .flag_q(flag_q), .rst_req(rst_req)
);

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
  logic        clk = 1'b0;
  logic        por = 1'b1, sys_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rst_req, rst_cold, tmo_out;

  int vecs = 0, errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  keyed_watchdog #(.CNT_W(32), .DIV_FAST(2), .DIV_SLOW(4)) uut (
    .clk(clk), .por(por), .sys_rst(sys_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .rst_req(rst_req), .rst_cold(rst_cold), .tmo_out(tmo_out)
  );

  typedef struct packed {
    logic        rd;
    logic [5:0]  ad;
    logic [31:0] dt;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VTAB [NV] = '{
    '{1'b1, 6'h00, 32'h00, 4'd1},   // R1 preload 1 clear
    '{1'b1, 6'h18, 32'h00, 4'd1},   // R1 lock register clear
    '{1'b0, 6'h00, 32'h05, 4'd2},   // R2 no key
    '{1'b1, 6'h00, 32'h00, 4'd2},   // R2 discarded
    '{1'b0, 6'h0C, 32'h80, 4'd2},
    '{1'b0, 6'h0C, 32'h86, 4'd2},
    '{1'b0, 6'h00, 32'h11, 4'd2},
    '{1'b1, 6'h00, 32'h11, 4'd2},   // R2 accepted
    '{1'b0, 6'h04, 32'h22, 4'd4},   // R4 second write after one key
    '{1'b1, 6'h04, 32'h00, 4'd4},
    '{1'b0, 6'h0C, 32'h80, 4'd3},   // R3 wrong second byte
    '{1'b0, 6'h0C, 32'h85, 4'd3},
    '{1'b0, 6'h0C, 32'h86, 4'd3},
    '{1'b0, 6'h04, 32'h33, 4'd3},
    '{1'b1, 6'h04, 32'h00, 4'd3},
    '{1'b0, 6'h0C, 32'h80, 4'd3},   // R3 foreign write between key bytes
    '{1'b0, 6'h10, 32'h04, 4'd3},
    '{1'b0, 6'h0C, 32'h86, 4'd3},
    '{1'b0, 6'h04, 32'h44, 4'd3},
    '{1'b1, 6'h04, 32'h00, 4'd3},
    '{1'b1, 6'h10, 32'h04, 4'd6},   // R6 config readback
    '{1'b0, 6'h0C, 32'h80, 4'd2},
    '{1'b0, 6'h0C, 32'h86, 4'd2},
    '{1'b0, 6'h04, 32'h44, 4'd2},
    '{1'b1, 6'h04, 32'h44, 4'd2},
    '{1'b0, 6'h14, 32'h99, 4'd7},   // R7 count not writable
    '{1'b1, 6'h14, 32'h00, 4'd7}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rd_addr = a;
    @(posedge clk); #1;
    d = rd_data;
  endtask

  task automatic unlock();
    wr(6'h0C, 32'h80);
    wr(6'h0C, 32'h86);
  endtask

  // edges until rst_req is seen, 0 if none within lim
  task automatic wait_req(input int lim, output int k);
    k = 0;
    for (int i = 1; i <= lim; i++) begin
      @(posedge clk); #1;
      if (rst_req) begin k = i; break; end
    end
  endtask

  task automatic count_req(input int lim, output int n);
    n = 0;
    for (int i = 0; i < lim; i++) begin
      @(posedge clk); #1;
      if (rst_req) n++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; vecs++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int k;
    repeat (3) @(posedge clk); #1;
    por = 1'b0;
    chk("R1 rst_req", {31'b0, rst_req}, 0);
    chk("R1 tmo_out", {31'b0, tmo_out}, 0);
    chk("R1 rst_cold", {31'b0, rst_cold}, 0);

    for (int i = 0; i < NV; i++) begin
      if (VTAB[i].rd) begin
        rd(VTAB[i].ad, v);
        chk($sformatf("R%0d table %0d", VTAB[i].rq, i), v, VTAB[i].dt);
      end else begin
        wr(VTAB[i].ad, VTAB[i].dt);
      end
    end

    // R5 two-stage timing with fast ticks, R11 restart mode
    unlock(); wr(6'h00, 32'd3);
    unlock(); wr(6'h04, 32'd2);
    wr(6'h10, 32'h10);
    rd_addr = 6'h14;
    wr(6'h18, 32'h02);
    wait_req(400, k);
    chk("R5 edges to expiry (fast)", k, 14);
    @(posedge clk); #1;
    chk("R5 pulse one cycle", {31'b0, rst_req}, 0);
    chk("R11 restart from preload 1", rd_data, 3);
    chk("R13 warm type", {31'b0, rst_cold}, 0);
    rd(6'h0D, v);
    chk("R8 flag set", v, 32'h2);
    chk("R8 output gated off", {31'b0, tmo_out}, 0);

    // R10 disable holds count
    wr(6'h18, 32'h00);
    rd(6'h14, v);
    repeat (10) @(posedge clk); #1;
    rd(6'h14, v2);
    chk("R10 count held", v2, v);

    // R6 slow ticks, R13 cold type, R11 halt mode
    wr(6'h10, 32'h1C);
    wr(6'h18, 32'h06);
    wait_req(400, k);
    chk("R6 edges to expiry (slow)", k, 28);
    chk("R13 cold type", {31'b0, rst_cold}, 1);
    count_req(60, k);
    chk("R11 no request while halted", k, 0);
    rd(6'h14, v);
    chk("R11 halted at zero", v, 0);
    unlock(); wr(6'h0D, 32'h01);
    wait_req(400, k);
    chk("R7 reload restarts both stages", k, 28);
    wr(6'h18, 32'h00);

    // R8 output enable and flag clearing
    wr(6'h10, 32'h3C);
    @(posedge clk); #1;
    chk("R8 tmo_out follows flag", {31'b0, tmo_out}, 1);
    wr(6'h0D, 32'h02);
    rd(6'h0D, v);
    chk("R2 flag clear without key ignored", v, 32'h2);
    unlock(); wr(6'h0D, 32'h02);
    rd(6'h0D, v);
    chk("R8 flag cleared", v, 0);
    chk("R8 tmo_out drops", {31'b0, tmo_out}, 0);

    // R8 flag without reset action; R5 no pulse
    wr(6'h10, 32'h00);
    wr(6'h18, 32'h02);
    count_req(40, k);
    chk("R5 no request when action disabled", k, 0);
    rd(6'h0D, v);
    chk("R8 flag set without action", v, 32'h2);
    wr(6'h18, 32'h00);

    // R9 lock
    wr(6'h10, 32'h10);
    wr(6'h18, 32'h03);
    wr(6'h10, 32'h04);
    rd(6'h10, v);
    chk("R9 config frozen", v, 32'h10);
    unlock(); wr(6'h00, 32'd7);
    rd(6'h00, v);
    chk("R9 preload frozen", v, 3);
    wr(6'h18, 32'h00);
    rd(6'h18, v);
    chk("R9 lock register frozen", v, 32'h3);
    unlock();
    rd_addr = 6'h14;
    wr(6'h0D, 32'h01);
    @(posedge clk); #1;
    chk("R9 reload accepted while locked", rd_data, 3);
    wait_req(400, k);
    chk("R9 still expires", {31'b0, (k != 0)}, 1);

    // R12 system reset keeps flag
    @(posedge clk); #1;
    sys_rst = 1'b1;
    repeat (2) @(posedge clk); #1;
    sys_rst = 1'b0;
    rd(6'h18, v);
    chk("R12 lock cleared", v, 0);
    rd(6'h00, v);
    chk("R12 preload cleared", v, 0);
    rd(6'h0D, v);
    chk("R12 flag kept", v, 32'h2);
    chk("R12 rst_cold cleared", {31'b0, rst_cold}, 0);
    por = 1'b1;
    repeat (2) @(posedge clk); #1;
    por = 1'b0;
    rd(6'h0D, v);
    chk("R12 power-on clears flag", v, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule